// File: doc/BRIEF.md
# Configurable Macrocell Storage Element

This block is the storage stage of a programmable-logic macrocell. One element can act as a D flip-flop, a T flip-flop or a transparent latch. An XOR stage in front of the element lets a flip-flop emulate J-K or S-R behaviour. In that case the logic terms are split into two halves, one per control input, and the stored output is fed back into the XOR. The element's input polarity can be inverted in every mode.

Its clock or latch enable comes from one of four clocks shared across the block (synchronous mode) or from one individual clock term (asynchronous mode). The active polarity is programmable. Block-wide reset and preset terms force the output whatever the clock is doing. A power-on reset input loads a configured initial state.

The element is modelled in a sampled domain. A fast system clock `clk` samples every term and clock line. An active edge of the selected clock is found by comparing its level with its level one sample earlier, and `q` is a register on `clk`. All configuration inputs are static while the block runs.

Top module: `mc_cell`

## Requirements
- R1: With `cfg_store` = 0 (or 3) the element is a D flip-flop. On a sample where the selected clock shows an active edge, `q` takes the element input. On every other sample `q` holds.
- R2: With `cfg_store` = 1 the element is a T flip-flop. On an active edge an element input of 1 inverts `q` and an input of 0 holds it. Between edges `q` holds.
- R3: With `cfg_store` = 2 the element is a latch. While the selected clock is at its active level, `q` takes the element input on each sample. Otherwise `q` holds. The latch ignores `cfg_emu` and always uses the direct input of R4.
- R4: With `cfg_emu` = 0 (or 3) the element input is the OR of all of `terms`, XORed with `xor_term`.
- R5: With `cfg_emu` = 1 on a flip-flop, J is the OR of the lower half of `terms` and K is the OR of the upper half. The next state is (J & ~Q) | (~K & Q) on both D and T elements, and `xor_term` has no effect.
- R6: With `cfg_emu` = 2 on a flip-flop, S is the OR of the lower half of `terms` and R is the OR of the upper half. S alone gives 1, R alone gives 0, and neither or both hold Q. `xor_term` has no effect.
- R7: With `cfg_dinv` = 1 the element input formed by R4 to R6 is inverted before the storage element, in every storage type.
- R8: With `cfg_async` = 0 the clock is `blk_clk[cfg_csel]`. The other block clocks and `ind_clk` have no effect.
- R9: With `cfg_async` = 1 the clock is `ind_clk`, and `blk_clk` has no effect.
- R10: With `cfg_cpol` = 0 the rising edge is active and a high level makes the latch transparent. With `cfg_cpol` = 1 the falling edge and the low level are active.
- R11: When `rst` is low, `blk_ar` = 1 drives `q` to 0 on the next sample and `blk_ap` = 1 drives it to 1, in either clock mode and whatever the clock does. If both are 1, the reset wins and `q` is 0.
- R12: While `rst` is 1, `q` is loaded with `cfg_init` on each sample, and `rst` overrides every other input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous power-on reset, active high |
| cfg_store | input | 2 | Storage type: 0 D flip-flop, 1 T flip-flop, 2 latch, 3 D flip-flop |
| cfg_emu | input | 2 | Input mode: 0 direct, 1 J-K, 2 S-R, 3 direct |
| cfg_async | input | 1 | 1 selects the individual clock term |
| cfg_csel | input | CSW | Block clock index in synchronous mode |
| cfg_cpol | input | 1 | 1 makes the falling edge and the low level active |
| cfg_dinv | input | 1 | Inverts the element input |
| cfg_init | input | 1 | State loaded at power-on reset |
| terms | input | NTERM | Logic term inputs |
| xor_term | input | 1 | Extra XOR operand in direct mode |
| blk_clk | input | NCLK | Shared block clocks |
| ind_clk | input | 1 | Individual clock term |
| blk_ar | input | 1 | Block-wide asynchronous reset term |
| blk_ap | input | 1 | Block-wide asynchronous preset term |
| q | output | 1 | Stored output |

## Verification
The bench sweeps every storage type, input mode, polarity, initial state and clock source. In each configuration it toggles all clock lines and terms at random and compares `q` with an arithmetic model on every sample. The runs cover S and R both set, where a design that lets one side win would move `q` instead of holding it. They cover reset and preset asserted together, where a wrong priority would leave `q` at 1. Unselected clocks toggle throughout, so a wrong clock mux would update `q` on foreign edges. A latch is run with J-K or S-R configured, where a design that failed to ignore the mode would lose the direct XOR data. Falling polarity is covered too, where a design that ignored the setting would capture one half-period off.

// File: rtl/mc_pkg.sv
package mc_pkg;
  typedef enum logic [1:0] {
    ST_DFF = 2'd0,
    ST_TFF = 2'd1,
    ST_LAT = 2'd2,
    ST_DF2 = 2'd3
  } store_e;

  typedef enum logic [1:0] {
    EM_DIRECT = 2'd0,
    EM_JK     = 2'd1,
    EM_SR     = 2'd2,
    EM_DIR2   = 2'd3
  } emu_e;
endpackage

// File: rtl/mc_clk_pick.sv
module mc_clk_pick #(
  parameter int NCLK = 4,
  localparam int CSW = (NCLK > 1) ? $clog2(NCLK) : 1
) (
  input  logic            clk,
  input  logic            cfg_async,
  input  logic [CSW-1:0]  cfg_csel,
  input  logic            cfg_cpol,
  input  logic [NCLK-1:0] blk_clk,
  input  logic            ind_clk,
  output logic            lvl,
  output logic            fire
);
  logic [NCLK-1:0] hit;
  logic            sync_src;
  logic            lvl_prev;

  // one-hot pick of the shared clock
  genvar gi;
  generate
    for (gi = 0; gi < NCLK; gi++) begin : g_pick
      assign hit[gi] = blk_clk[gi] & (cfg_csel == CSW'(gi));
    end
  endgenerate

  assign sync_src = |hit;
  assign lvl      = (cfg_async ? ind_clk : sync_src) ^ cfg_cpol;

  always_ff @(posedge clk) begin
    lvl_prev <= lvl;
  end

  assign fire = lvl & ~lvl_prev;
endmodule

// File: rtl/mc_xor_stage.sv
module mc_xor_stage #(
  parameter int NTERM = 4,
  localparam int HALF = NTERM / 2
) (
  input  logic [NTERM-1:0] terms,
  input  logic             xor_term,
  input  logic             q,
  input  logic [1:0]       cfg_store,
  input  logic [1:0]       cfg_emu,
  input  logic             cfg_dinv,
  output logic             elem_in
);
  import mc_pkg::*;

  store_e st;
  emu_e   em;
  logic   grp_lo, grp_hi, sum_all, tog, raw;

  assign st      = store_e'(cfg_store);
  assign em      = emu_e'(cfg_emu);
  assign grp_lo  = |terms[HALF-1:0];
  assign grp_hi  = |terms[NTERM-1:HALF];
  assign sum_all = grp_lo | grp_hi;

  always_comb begin
    tog = 1'b0;
    raw = sum_all ^ xor_term;
    if (st != ST_LAT) begin
      case (em)
        EM_JK: begin
          tog = (grp_lo & ~q) | (grp_hi & q);
          raw = (st == ST_TFF) ? tog : (q ^ tog);
        end
        EM_SR: begin
          tog = (grp_lo & ~grp_hi & ~q) | (grp_hi & ~grp_lo & q);
          raw = (st == ST_TFF) ? tog : (q ^ tog);
        end
        default: begin
          tog = 1'b0;
        end
      endcase
    end
    elem_in = raw ^ cfg_dinv;
  end
endmodule

// File: rtl/mc_store.sv
module mc_store (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] cfg_store,
  input  logic       cfg_init,
  input  logic       blk_ar,
  input  logic       blk_ap,
  input  logic       lvl,
  input  logic       fire,
  input  logic       elem_in,
  output logic       q
);
  import mc_pkg::*;

  store_e st;
  assign st = store_e'(cfg_store);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= cfg_init;
    end else if (blk_ar) begin
      q <= 1'b0;
    end else if (blk_ap) begin
      q <= 1'b1;
    end else begin
      case (st)
        ST_LAT:  if (lvl)  q <= elem_in;
        ST_TFF:  if (fire) q <= q ^ elem_in;
        default: if (fire) q <= elem_in;
      endcase
    end
  end
endmodule

// File: rtl/mc_cell.sv
module mc_cell #(
  parameter int NTERM = 4,
  parameter int NCLK  = 4,
  localparam int CSW  = (NCLK > 1) ? $clog2(NCLK) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       cfg_store,
  input  logic [1:0]       cfg_emu,
  input  logic             cfg_async,
  input  logic [CSW-1:0]   cfg_csel,
  input  logic             cfg_cpol,
  input  logic             cfg_dinv,
  input  logic             cfg_init,
  input  logic [NTERM-1:0] terms,
  input  logic             xor_term,
  input  logic [NCLK-1:0]  blk_clk,
  input  logic             ind_clk,
  input  logic             blk_ar,
  input  logic             blk_ap,
  output logic             q
);
  logic lvl, fire, elem_in;

  mc_clk_pick #(.NCLK(NCLK)) u_clk (
    .clk      (clk),
    .cfg_async(cfg_async),
    .cfg_csel (cfg_csel),
    .cfg_cpol (cfg_cpol),
    .blk_clk  (blk_clk),
    .ind_clk  (ind_clk),
    .lvl      (lvl),
    .fire     (fire)
  );

  mc_xor_stage #(.NTERM(NTERM)) u_xor (
    .terms    (terms),
    .xor_term (xor_term),
    .q        (q),
    .cfg_store(cfg_store),
    .cfg_emu  (cfg_emu),
    .cfg_dinv (cfg_dinv),
    .elem_in  (elem_in)
  );

  mc_store u_store (
    .clk      (clk),
    .rst      (rst),
    .cfg_store(cfg_store),
    .cfg_init (cfg_init),
    .blk_ar   (blk_ar),
    .blk_ap   (blk_ap),
    .lvl      (lvl),
    .fire     (fire),
    .elem_in  (elem_in),
    .q        (q)
  );
endmodule

// File: rtl/mc_cell_chk.sv
module mc_cell_chk #(
  parameter int NTERM = 4,
  parameter int NCLK  = 4,
  localparam int CSW  = (NCLK > 1) ? $clog2(NCLK) : 1
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       cfg_store,
  input logic [1:0]       cfg_emu,
  input logic             cfg_async,
  input logic [CSW-1:0]   cfg_csel,
  input logic             cfg_cpol,
  input logic             cfg_dinv,
  input logic             cfg_init,
  input logic [NTERM-1:0] terms,
  input logic             xor_term,
  input logic [NCLK-1:0]  blk_clk,
  input logic             ind_clk,
  input logic             blk_ar,
  input logic             blk_ap,
  input logic             q
);
  logic act_lvl, is_ff, is_direct, quiet, direct_in;

  assign act_lvl   = (cfg_async ? ind_clk : blk_clk[cfg_csel]) ^ cfg_cpol;
  assign is_ff     = (cfg_store != 2'd2);
  assign is_direct = (cfg_emu == 2'd0) || (cfg_emu == 2'd3);
  assign quiet     = !blk_ar && !blk_ap;
  assign direct_in = (|terms) ^ xor_term ^ cfg_dinv;

  AST_POR_INIT: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (q == cfg_init)); // R12

  AST_RESET_WINS: assert property (@(posedge clk) disable iff (rst)
    blk_ar |=> !q); // R11

  AST_PRESET_SETS: assert property (@(posedge clk) disable iff (rst)
    (blk_ap && !blk_ar) |=> q); // R11

  AST_FF_HOLD: assert property (@(posedge clk) disable iff (rst)
    (quiet && is_ff && !(act_lvl && !$past(act_lvl))) |=> $stable(q)); // R1

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    (quiet && !is_ff && !act_lvl) |=> $stable(q)); // R3

  AST_T_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    (quiet && cfg_store == 2'd1 && is_direct && act_lvl && !$past(act_lvl)
     && direct_in) |=> (q != $past(q))); // R2
endmodule

bind mc_cell mc_cell_chk #(.NTERM(NTERM), .NCLK(NCLK)) u_chk (.*);

// File: tb/sim_mc_cell.sv
module sim_mc_cell;
  localparam int NT = 4;
  localparam int NC = 4;
  localparam int NSTEP = 48;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] cfg_store = 2'd0, cfg_emu = 2'd0;
  logic cfg_async = 1'b0, cfg_cpol = 1'b0, cfg_dinv = 1'b0, cfg_init = 1'b0;
  logic [1:0] cfg_csel = 2'd0;
  logic [NT-1:0] terms = '0;
  logic xor_term = 1'b0;
  logic [NC-1:0] blk_clk = '0;
  logic ind_clk = 1'b0, blk_ar = 1'b0, blk_ap = 1'b0;
  logic q;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic exp_q;
  logic prev_lvl;
  string tag;

  always #4 clk = ~clk;

  mc_cell #(.NTERM(NT), .NCLK(NC)) u0 (
    .clk(clk), .rst(rst), .cfg_store(cfg_store), .cfg_emu(cfg_emu),
    .cfg_async(cfg_async), .cfg_csel(cfg_csel), .cfg_cpol(cfg_cpol),
    .cfg_dinv(cfg_dinv), .cfg_init(cfg_init), .terms(terms),
    .xor_term(xor_term), .blk_clk(blk_clk), .ind_clk(ind_clk),
    .blk_ar(blk_ar), .blk_ap(blk_ap), .q(q)
  );

  task automatic check_q();
    total++;
    if (q !== exp_q) begin
      bad++;
      $display("FAIL %s st=%0d em=%0d inv=%0b pol=%0b async=%0b sel=%0d q=%0b expected %0b",
               tag, cfg_store, cfg_emu, cfg_dinv, cfg_cpol, cfg_async, cfg_csel, q, exp_q);
    end
  endtask

  // next state from the requirements, using the values driven this cycle
  task automatic model_step();
    logic lvl, j, k, nxt, din;
    lvl = (cfg_async ? ind_clk : blk_clk[cfg_csel]) ^ cfg_cpol;
    j = |terms[NT/2-1:0];
    k = |terms[NT-1:NT/2];
    tag = cfg_async ? "R9" : "R8";
    if (cfg_cpol) tag = {tag, " R10"};
    if (cfg_dinv) tag = {tag, " R7"};
    if (rst) begin
      exp_q = cfg_init; tag = "R12";
    end else if (blk_ar || blk_ap) begin
      exp_q = blk_ar ? 1'b0 : 1'b1; tag = {tag, " R11"};
    end else if (cfg_store == 2'd2) begin
      tag = {tag, " R3 R4"};
      din = ((j | k) ^ xor_term) ^ cfg_dinv;
      if (lvl) exp_q = din;
    end else if (lvl && !prev_lvl) begin
      if (cfg_emu == 2'd1) begin
        tag = {tag, " R5"};
        nxt = (j & ~exp_q) | (~k & exp_q);
        din = ((cfg_store == 2'd1) ? (nxt ^ exp_q) : nxt) ^ cfg_dinv;
      end else if (cfg_emu == 2'd2) begin
        tag = {tag, " R6"};
        nxt = (j && !k) ? 1'b1 : (k && !j) ? 1'b0 : exp_q;
        din = ((cfg_store == 2'd1) ? (nxt ^ exp_q) : nxt) ^ cfg_dinv;
      end else begin
        tag = {tag, " R4"};
        din = ((j | k) ^ xor_term) ^ cfg_dinv;
      end
      if (cfg_store == 2'd1) begin
        tag = {tag, " R2"}; exp_q = exp_q ^ din;
      end else begin
        tag = {tag, " R1"}; exp_q = din;
      end
    end else begin
      tag = {tag, (cfg_store == 2'd1) ? " R2 hold" : " R1 hold"};
    end
    prev_lvl = lvl;
  endtask

  task automatic drive_random();
    terms    = NT'($urandom);
    xor_term = 1'($urandom);
    blk_clk  = NC'($urandom);
    ind_clk  = 1'($urandom);
    blk_ar   = (($urandom % 10) == 0);
    blk_ap   = (($urandom % 9) == 0);
  endtask

  initial begin
    exp_q = 1'b0;
    prev_lvl = 1'b0;
    tag = "R12";
    for (int st = 0; st < 3; st++)
      for (int em = 0; em < 3; em++)
        for (int dv = 0; dv < 2; dv++)
          for (int ini = 0; ini < 2; ini++)
            for (int cp = 0; cp < 2; cp++)
              for (int md = 0; md < 5; md++) begin
                @(negedge clk);
                cfg_store = 2'(st);
                cfg_emu   = 2'(em);
                cfg_dinv  = 1'(dv);
                cfg_init  = 1'(ini);
                cfg_cpol  = 1'(cp);
                cfg_async = (md == 4);
                cfg_csel  = 2'(md % 4);
                rst = 1'b1;
                drive_random();
                model_step();
                for (int s = 0; s < NSTEP; s++) begin
                  @(negedge clk);
                  check_q();
                  rst = 1'b0;
                  drive_random();
                  model_step();
                end
                @(negedge clk);
                check_q();
              end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule